// File: doc/BRIEF.md
# Serial Configuration Word Receiver

This block takes configuration words sent over a three-wire serial link (a bit clock, a data line and a load strobe) and turns them into the static settings a frequency synthesizer's dividers and phase detector need. The three serial lines are asynchronous to the block's system clock. Each line passes through a two-stage synchroniser, and edges of the bit clock and the strobe are detected in the system clock domain.

Every rising edge of the bit clock moves the sampled data bit into an 18-bit shift register, most significant bit first. The last bit shifted in is the destination selector. On a rising edge of the strobe the shift register is copied into one of two holding latches. The reference latch holds the reference divider count and the detector polarity. The feedback latch holds the A swallow count, the B count and a power-down request. A chip-enable input combines with the programmed power-down request into one power-down output. The serial path keeps shifting and latching while the chip is disabled.

Top module: `serial_cfg_port`

## Requirements
- R1: After the asynchronous reset, every latched field (ref_count, a_count, b_count, pd_bit, pol_invert) is zero.
- R2: Each rising edge of ser_clk shifts ser_data into bit 0 of an 18-bit shift register. Bits move toward bit 17, so the first bit sent ends up as bit 17 once 18 bits have arrived.
- R3: On a rising edge of ser_le with word bit 0 equal to 0, the reference latch loads ref_count from word bits [10:1] and pol_invert from bit 17. The feedback fields stay unchanged.
- R4: On a rising edge of ser_le with word bit 0 equal to 1, the feedback latch loads a_count from bits [5:1], b_count from bits [15:6] and pd_bit from bit 16. The reference fields stay unchanged.
- R5: Shifting bits without a rising edge on ser_le changes no output field.
- R6: Bits shifted while ser_le is held high are still shifted in. They are committed only at the next rising edge of ser_le.
- R7: If more than 18 bits are sent before a commit, only the last 18 are used.
- R8: powered_down is 1 when chip_en is 0 or pd_bit is 1, and 0 otherwise.
- R9: With chip_en at 0, words are still shifted and committed to the selected latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Load strobe; a rising edge commits the word |
| chip_en | input | 1 | Chip enable; low forces power-down |
| ref_count | output | 10 | Reference divider count |
| a_count | output | 5 | A swallow count |
| b_count | output | 10 | B count |
| pd_bit | output | 1 | Programmed power-down request |
| pol_invert | output | 1 | Phase detector polarity select |
| powered_down | output | 1 | Effective power-down state |

## Verification
The bench sends words longer than 18 bits. A design that kept the leading bits instead of the trailing ones would latch garbage fields. It also holds the strobe high for a whole word. A design that committed on strobe level rather than its edge would update the outputs before the final rising edge. Writes to each latch are followed by checks on the other latch's fields, which catches a swapped selector polarity or an unconditional load. A write made while chip enable is low catches an interface that wrongly stalls during power-down.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

    typedef enum logic {
        DEST_REF = 1'b0,
        DEST_FB  = 1'b1
    } dest_e;

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.chain[STAGES-1];

endmodule

// File: rtl/scp_edge.sv
module scp_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     level;

    scp_sync #(.STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (async_in),
        .sync_out (level)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = level & ~st_q.prev;

endmodule

// File: rtl/scp_shift.sv
module scp_shift #(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word
);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.sr;

endmodule

// File: rtl/scp_latch_bank.sv
module scp_latch_bank
    import serial_cfg_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int A_W    = 5,
    parameter int B_W    = 10,
    parameter int R_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [WORD_W-1:0] word,
    output logic [R_W-1:0]    ref_count,
    output logic              pol_invert,
    output logic [A_W-1:0]    a_count,
    output logic [B_W-1:0]    b_count,
    output logic              pd_bit
);

    localparam int A_LO   = 1;
    localparam int A_HI   = A_LO + A_W - 1;
    localparam int B_LO   = A_HI + 1;
    localparam int B_HI   = B_LO + B_W - 1;
    localparam int PD_POS = B_HI + 1;
    localparam int R_LO   = 1;
    localparam int R_HI   = R_LO + R_W - 1;
    localparam int POL_POS = WORD_W - 1;

    typedef struct packed {
        logic [R_W-1:0] r;
        logic           pol;
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic           pd;
    } bank_st_t;

    bank_st_t st_d, st_q;
    dest_e    dest;

    assign dest = dest_e'(word[0]);

    always_comb begin
        st_d = st_q;
        if (commit) begin
            case (dest)
                DEST_REF: begin
                    st_d.r   = word[R_HI:R_LO];
                    st_d.pol = word[POL_POS];
                end
                DEST_FB: begin
                    st_d.a  = word[A_HI:A_LO];
                    st_d.b  = word[B_HI:B_LO];
                    st_d.pd = word[PD_POS];
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ref_count  = st_q.r;
    assign pol_invert = st_q.pol;
    assign a_count    = st_q.a;
    assign b_count    = st_q.b;
    assign pd_bit     = st_q.pd;

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
    parameter int WORD_W = 18,
    parameter int A_W    = 5,
    parameter int B_W    = 10,
    parameter int R_W    = 10,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_le,
    input  logic           chip_en,
    output logic [R_W-1:0] ref_count,
    output logic [A_W-1:0] a_count,
    output logic [B_W-1:0] b_count,
    output logic           pd_bit,
    output logic           pol_invert,
    output logic           powered_down
);

    logic              sclk_rise;
    logic              le_rise;
    logic              data_s;
    logic [WORD_W-1:0] word;

    scp_edge #(.STAGES(STAGES)) u_clk_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ser_clk),
        .rise     (sclk_rise)
    );

    scp_edge #(.STAGES(STAGES)) u_le_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ser_le),
        .rise     (le_rise)
    );

    scp_sync #(.STAGES(STAGES)) u_data_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ser_data),
        .sync_out (data_s)
    );

    scp_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sclk_rise),
        .bit_in   (data_s),
        .word     (word)
    );

    scp_latch_bank #(
        .WORD_W (WORD_W),
        .A_W    (A_W),
        .B_W    (B_W),
        .R_W    (R_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (le_rise),
        .word       (word),
        .ref_count  (ref_count),
        .pol_invert (pol_invert),
        .a_count    (a_count),
        .b_count    (b_count),
        .pd_bit     (pd_bit)
    );

    assign powered_down = ~chip_en | pd_bit;

endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk #(
    parameter int WORD_W = 18,
    parameter int A_W    = 5,
    parameter int B_W    = 10,
    parameter int R_W    = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_rise,
    input logic              le_rise,
    input logic              data_s,
    input logic [WORD_W-1:0] word,
    input logic [R_W-1:0]    ref_count,
    input logic [A_W-1:0]    a_count,
    input logic [B_W-1:0]    b_count,
    input logic              pd_bit,
    input logic              pol_invert
);

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> word == {$past(word[WORD_W-2:0]), $past(data_s)}); // R2

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(word)); // R2

    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> $stable(ref_count) && $stable(pol_invert)); // R5

    AST_FB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> $stable(a_count) && $stable(b_count) && $stable(pd_bit)); // R5

    AST_REF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && !word[0]) |=> ref_count == $past(word[R_W:1])); // R3

    AST_REF_SPARES_FB: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && !word[0]) |=> $stable(a_count) && $stable(b_count) && $stable(pd_bit)); // R3

    AST_FB_SPARES_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && word[0]) |=> $stable(ref_count) && $stable(pol_invert)); // R4

endmodule

bind serial_cfg_port serial_cfg_port_chk #(
    .WORD_W (WORD_W),
    .A_W    (A_W),
    .B_W    (B_W),
    .R_W    (R_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_rise  (sclk_rise),
    .le_rise    (le_rise),
    .data_s     (data_s),
    .word       (word),
    .ref_count  (ref_count),
    .a_count    (a_count),
    .b_count    (b_count),
    .pd_bit     (pd_bit),
    .pol_invert (pol_invert)
);

// File: tb/sim_serial_cfg_port.sv
`timescale 1ns/1ps
module sim_serial_cfg_port;

    localparam int HOLD  = 6;
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_le = 1'b0;
    logic       chip_en = 1'b1;
    logic [9:0] ref_count;
    logic [4:0] a_count;
    logic [9:0] b_count;
    logic       pd_bit;
    logic       pol_invert;
    logic       powered_down;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_cfg_port u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_clk      (ser_clk),
        .ser_data     (ser_data),
        .ser_le       (ser_le),
        .chip_en      (chip_en),
        .ref_count    (ref_count),
        .a_count      (a_count),
        .b_count      (b_count),
        .pd_bit       (pd_bit),
        .pol_invert   (pol_invert),
        .powered_down (powered_down)
    );

    function automatic logic [17:0] mk_ref(input logic [9:0] r, input logic pol);
        return {pol, 6'b0, r, 1'b0};
    endfunction

    function automatic logic [17:0] mk_fb(input logic [4:0] a, input logic [9:0] b, input logic pd);
        return {1'b0, pd, b, a, 1'b1};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [63:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i];
            wait_cyc(HOLD);
            ser_clk = 1'b1;
            wait_cyc(HOLD);
            ser_clk = 1'b0;
        end
        wait_cyc(HOLD);
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        wait_cyc(HOLD);
        ser_le = 1'b0;
        wait_cyc(HOLD);
    endtask

    task automatic expect_all(input string req, input logic [9:0] r, input logic pol,
                              input logic [4:0] a, input logic [9:0] b, input logic pd);
        chk({req, " ref_count"}, 32'(ref_count), 32'(r));
        chk({req, " pol_invert"}, 32'(pol_invert), 32'(pol));
        chk({req, " a_count"}, 32'(a_count), 32'(a));
        chk({req, " b_count"}, 32'(b_count), 32'(b));
        chk({req, " pd_bit"}, 32'(pd_bit), 32'(pd));
    endtask

    task automatic t_reset();
        expect_all("R1", 10'd0, 1'b0, 5'd0, 10'd0, 1'b0);
        chk("R8 enabled no pd", 32'(powered_down), 32'd0);
    endtask

    task automatic t_ref_write();
        send_bits(64'(mk_ref(10'h2A5, 1'b1)), 18);
        expect_all("R5 before strobe", 10'd0, 1'b0, 5'd0, 10'd0, 1'b0);
        pulse_le();
        expect_all("R3 R2", 10'h2A5, 1'b1, 5'd0, 10'd0, 1'b0);
    endtask

    task automatic t_fb_write();
        send_bits(64'(mk_fb(5'h13, 10'h3C6, 1'b0)), 18);
        pulse_le();
        expect_all("R4", 10'h2A5, 1'b1, 5'h13, 10'h3C6, 1'b0);
    endtask

    task automatic t_no_strobe();
        send_bits(64'(mk_ref(10'h0F0, 1'b0)), 18);
        send_bits(64'(mk_fb(5'h1F, 10'h001, 1'b1)), 18);
        expect_all("R5", 10'h2A5, 1'b1, 5'h13, 10'h3C6, 1'b0);
    endtask

    task automatic t_le_held_high();
        ser_le = 1'b1;
        wait_cyc(HOLD);
        send_bits(64'(mk_ref(10'h155, 1'b0)), 18);
        expect_all("R6 held high", 10'h2A5, 1'b1, 5'h1F, 10'h001, 1'b1);
        ser_le = 1'b0;
        wait_cyc(HOLD);
        expect_all("R6 falling edge", 10'h2A5, 1'b1, 5'h1F, 10'h001, 1'b1);
        pulse_le();
        expect_all("R6 next rise", 10'h155, 1'b0, 5'h1F, 10'h001, 1'b1);
    endtask

    task automatic t_long_word();
        send_bits({42'd0, 4'b1011, mk_fb(5'h05, 10'h2B3, 1'b0)}, 22);
        pulse_le();
        expect_all("R7", 10'h155, 1'b0, 5'h05, 10'h2B3, 1'b0);
    endtask

    task automatic t_chip_disabled();
        chip_en = 1'b0;
        wait_cyc(2);
        chk("R8 chip_en low", 32'(powered_down), 32'd1);
        send_bits(64'(mk_ref(10'h3FF, 1'b1)), 18);
        pulse_le();
        expect_all("R9", 10'h3FF, 1'b1, 5'h05, 10'h2B3, 1'b0);
        chip_en = 1'b1;
        wait_cyc(2);
        chk("R8 chip_en high", 32'(powered_down), 32'd0);
    endtask

    task automatic t_pd_request();
        send_bits(64'(mk_fb(5'h0A, 10'h200, 1'b1)), 18);
        pulse_le();
        chk("R8 pd request", 32'(powered_down), 32'd1);
        chk("R4 pd field", 32'(pd_bit), 32'd1);
        send_bits(64'(mk_fb(5'h0A, 10'h200, 1'b0)), 18);
        pulse_le();
        chk("R8 pd cleared", 32'(powered_down), 32'd0);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        t_reset();
        t_ref_write();
        t_fb_write();
        t_no_strobe();
        t_le_held_high();
        t_long_word();
        t_chip_disabled();
        t_pd_request();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule